// File: doc/BRIEF.md
# Paged I2C Target Register Interface

This block lets an I2C host reach a register file that is split into pages. A fast system clock oversamples the SCL and SDA lines through synchronizers and finds start, repeated start and stop conditions and SCL edges. The block answers to a 7-bit target address. Its upper five bits are fixed at `11101`. The lower two bits come from a four-way strap selector.

After a matching write address, the first byte the host sends loads the register pointer. Each later byte is a data write at the pointer, and the pointer then moves up by one. One register address is not forwarded. A byte written there selects the page that all later accesses use. A read is set up by writing the page and the pointer, then issuing a repeated start with the read bit set. The block then returns bytes from an external combinational register port, moving the pointer after each byte the host acknowledges. Reads of any page other than the function page return zero unless the shutdown input is high.

Top module: `paged_i2c_target`

## Requirements
- R1: The first byte after a start is acknowledged only when its upper seven bits equal `11101` followed by the decoded strap bits. The strap decode maps `strapSel` 0 to 00, 1 to 11, 2 to 01 and 3 to 10. Bit 0 of that byte selects read (1) or write (0).
- R2: After an address byte that does not match, the block acknowledges nothing and produces no write strobe until the next start or stop.
- R3: The block pulls SDA low during the ninth clock pulse of a matching address byte, of the pointer byte and of every data byte the host writes. It leaves SDA released during the eight data bit pulses of a written byte. Its SDA drive changes only while SCL is low.
- R4: Every data byte written to a register other than the command address gives one single-cycle `wrEn` pulse. During that pulse `regAddr` holds the pointer, `regPage` holds the current page and `wrData` holds the byte. The pointer then rises by one, so a burst fills consecutive addresses.
- R5: A data byte written while the pointer equals the command address `0xFD` updates `regPage` to that byte and produces no `wrEn` pulse.
- R6: In a read, the block sends `rdData` for the current page and pointer MSB first. It increments the pointer after each byte the host acknowledges, so a burst returns consecutive registers.
- R7: When the host does not acknowledge a read byte, the block releases SDA and drives nothing further until the next start or stop.
- R8: Reads while `regPage` is the function page `0x0B` always return `rdData`. Reads of any other page return `0x00` while `shutdownActive` is low, and return `rdData` while it is high.
- R9: A repeated start at any bit position returns the block to address reception. The pointer and the page persist across it.
- R10: After reset, `sdaDriveLow` and `wrEn` are low, and `regPage` and `regAddr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| strapSel | input | 2 | Strap selector that sets the two low address bits |
| shutdownActive | input | 1 | High allows reads of the frame pages |
| rdData | input | 8 | Register contents at `regPage`/`regAddr` |
| sdaDriveLow | output | 1 | Open-drain drive: 1 pulls SDA low |
| wrEn | output | 1 | Single-cycle register write strobe |
| regAddr | output | 8 | Register pointer |
| regPage | output | 8 | Selected page |
| wrData | output | 8 | Byte to write |

## Verification
Each strap setting is tried with the matching address and with another strap's address, which separates the decode table from a fixed compare. Bursts of random length and content go to random pages and start pointers. Random reads follow, with the shutdown input at random, so pointer stepping, page capture and frame-page gating are checked together. Directed cases cover a burst that sets the page and must not strobe, a bus that is ignored after a wrong address, and a repeated start in the middle of a byte. They also cover a host that does not acknowledge and then keeps clocking, which must see SDA stay released.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W = 4;
  localparam logic [4:0] ADDR_HI = 5'b11101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_REG, ST_WDATA, ST_READ, ST_SKIP
  } pitState_e;

  typedef struct packed {
    logic shiftRx;
    logic loadPtr;
    logic incPtr;
    logic setPage;
    logic wrStrobe;
    logic loadTx;
    logic shiftTx;
  } pitCtl_t;

  function automatic logic [1:0] strapDecode(input logic [1:0] sel);
    case (sel)
      2'd0: strapDecode = 2'b00;
      2'd1: strapDecode = 2'b11;
      2'd2: strapDecode = 2'b01;
      default: strapDecode = 2'b10;
    endcase
  endfunction
endpackage

// File: rtl/pit_sync.sv
module pit_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= '1;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclRaw,
  input  logic    sdaRaw,
  input  logic    addrMatch,
  input  logic    rwBit,
  input  logic    ptrIsCmd,
  output logic    sdaSync,
  output pitCtl_t ctl,
  output logic    ackDrive,
  output logic    txActive
);
  logic [1:0] lineSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic sclRise, sclFall, startCond, stopCond, rxState;
  pitState_e state;
  logic [CNT_W-1:0] bitCnt;
  logic isRead, hostAck;

  pit_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din({sclRaw, sdaRaw}), .dout(lineSync)
  );

  assign sclNow = lineSync[1];
  assign sdaNow = lineSync[0];
  assign sdaSync = sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  assign startCond = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopCond = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign rxState = (state == ST_ADDR) || (state == ST_REG) || (state == ST_WDATA);

  // strobes to the datapath
  always_comb begin
    ctl = '0;
    if (!startCond && !stopCond) begin
      if (rxState && sclRise && bitCnt < 4'd8) ctl.shiftRx = 1'b1;
      if (sclFall && bitCnt == 4'd8) begin
        if (state == ST_REG) ctl.loadPtr = 1'b1;
        if (state == ST_WDATA) begin
          if (ptrIsCmd) ctl.setPage = 1'b1;
          else ctl.wrStrobe = 1'b1;
        end
      end
      if (sclFall && bitCnt == 4'd9) begin
        if (state == ST_WDATA) ctl.incPtr = 1'b1;
        if (state == ST_ADDR && isRead) ctl.loadTx = 1'b1;
        if (state == ST_READ && hostAck) ctl.loadTx = 1'b1;
      end
      if (state == ST_READ && sclRise && bitCnt == 4'd8 && !sdaNow) ctl.incPtr = 1'b1;
      if (state == ST_READ && sclFall && bitCnt >= 4'd1 && bitCnt <= 4'd7) ctl.shiftTx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
      hostAck <= 1'b0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (startCond || stopCond) begin
      state <= startCond ? ST_ADDR : ST_IDLE;
      bitCnt <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (rxState) begin
      if (sclRise && bitCnt < 4'd8) begin
        bitCnt <= bitCnt + 4'd1;
      end else if (sclFall && bitCnt == 4'd8) begin
        if (state == ST_ADDR && !addrMatch) begin
          state <= ST_SKIP;
        end else begin
          ackDrive <= 1'b1;
          bitCnt <= 4'd9;
          if (state == ST_ADDR) isRead <= rwBit;
        end
      end else if (sclFall && bitCnt == 4'd9) begin
        ackDrive <= 1'b0;
        bitCnt <= '0;
        if (state == ST_ADDR) begin
          state <= isRead ? ST_READ : ST_REG;
          txActive <= isRead;
        end else begin
          state <= ST_WDATA;
        end
      end
    end else if (state == ST_READ) begin
      if (sclRise && bitCnt < 4'd8) begin
        bitCnt <= bitCnt + 4'd1;
      end else if (sclRise && bitCnt == 4'd8) begin
        hostAck <= ~sdaNow;
        bitCnt <= 4'd9;
      end else if (sclFall && bitCnt == 4'd8) begin
        txActive <= 1'b0;
      end else if (sclFall && bitCnt == 4'd9) begin
        bitCnt <= '0;
        if (hostAck) txActive <= 1'b1;
        else state <= ST_SKIP;
      end
    end
  end
endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FUNC_PAGE = 8'h0B,
  parameter logic [BYTE_W-1:0] CMD_ADDR = 8'hFD
) (
  input  logic              clk,
  input  logic              rstN,
  input  pitCtl_t           ctl,
  input  logic              sdaBit,
  input  logic [1:0]        strapSel,
  input  logic              shutdownActive,
  input  logic [BYTE_W-1:0] rdData,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              ptrIsCmd,
  output logic              txMsb,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regPage,
  output logic              wrEn,
  output logic [BYTE_W-1:0] wrData
);
  logic [BYTE_W-1:0] rxByte, txByte, ptr, page, readValue;
  logic frameBlocked;

  assign addrMatch = rxByte[BYTE_W-1:1] == {ADDR_HI, strapDecode(strapSel)};
  assign rwBit = rxByte[0];
  assign ptrIsCmd = ptr == CMD_ADDR;
  assign frameBlocked = (page != FUNC_PAGE) && !shutdownActive;
  assign readValue = frameBlocked ? '0 : rdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txByte <= '0;
      ptr <= '0;
      page <= '0;
      wrEn <= 1'b0;
      wrData <= '0;
    end else begin
      if (ctl.shiftRx) rxByte <= {rxByte[BYTE_W-2:0], sdaBit};
      if (ctl.loadPtr) ptr <= rxByte;
      else if (ctl.incPtr) ptr <= ptr + 1'b1;
      if (ctl.setPage) page <= rxByte;
      wrEn <= ctl.wrStrobe;
      if (ctl.wrStrobe) wrData <= rxByte;
      if (ctl.loadTx) txByte <= readValue;
      else if (ctl.shiftTx) txByte <= {txByte[BYTE_W-2:0], 1'b0};
    end
  end

  assign txMsb = txByte[BYTE_W-1];
  assign regAddr = ptr;
  assign regPage = page;
endmodule

// File: rtl/paged_i2c_target.sv
module paged_i2c_target
  import pit_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FUNC_PAGE = 8'h0B,
  parameter logic [BYTE_W-1:0] CMD_ADDR = 8'hFD,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        strapSel,
  input  logic              shutdownActive,
  input  logic [BYTE_W-1:0] rdData,
  output logic              sdaDriveLow,
  output logic              wrEn,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regPage,
  output logic [BYTE_W-1:0] wrData
);
  pitCtl_t ctl;
  logic sdaSync, addrMatch, rwBit, ptrIsCmd, txMsb, ackDrive, txActive;

  pit_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRaw(sclIn), .sdaRaw(sdaIn),
    .addrMatch(addrMatch), .rwBit(rwBit), .ptrIsCmd(ptrIsCmd),
    .sdaSync(sdaSync), .ctl(ctl), .ackDrive(ackDrive), .txActive(txActive)
  );

  pit_datapath #(.FUNC_PAGE(FUNC_PAGE), .CMD_ADDR(CMD_ADDR)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaBit(sdaSync),
    .strapSel(strapSel), .shutdownActive(shutdownActive), .rdData(rdData),
    .addrMatch(addrMatch), .rwBit(rwBit), .ptrIsCmd(ptrIsCmd), .txMsb(txMsb),
    .regAddr(regAddr), .regPage(regPage), .wrEn(wrEn), .wrData(wrData)
  );

  assign sdaDriveLow = ackDrive | (txActive & ~txMsb);
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter logic [7:0] CMD_ADDR = 8'hFD
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaDriveLow,
  input logic       wrEn,
  input logic [7:0] regAddr,
  input logic [7:0] regPage
);
  a_r3_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn);
  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);
  a_r4_wr_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !sclIn);
  a_r5_no_cmd_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> regAddr != CMD_ADDR);
  a_r5_page_from_cmd: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regPage) |-> $past(regAddr) == CMD_ADDR);
endmodule

bind paged_i2c_target pit_checker #(.CMD_ADDR(CMD_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .wrEn(wrEn), .regAddr(regAddr), .regPage(regPage)
);

// File: tb/tb_paged_i2c_target.sv
module tb_paged_i2c_target;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic sdaHost = 1'b1;
  logic [1:0] strapSel = 2'd0;
  logic shutdownActive = 1'b0;
  logic [7:0] rdData;
  logic sdaDriveLow, wrEn;
  logic [7:0] regAddr, regPage, wrData;
  logic sdaBus;
  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 0;
  logic [7:0] evA [64];
  logic [7:0] evP [64];
  logic [7:0] evD [64];
  int evN = 0;
  int collide = 0;

  always #2.5 clk = ~clk;

  assign sdaBus = sdaHost & ~sdaDriveLow;

  function automatic logic [7:0] modelRd(input logic [7:0] p, input logic [7:0] a);
    return (p * 8'd37) ^ a ^ 8'hC3;
  endfunction

  function automatic logic [1:0] expStrap(input logic [1:0] s);
    case (s)
      2'd0: return 2'b00;
      2'd1: return 2'b11;
      2'd2: return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [7:0] addrByte(input logic [1:0] s, input logic rd);
    return {5'b11101, expStrap(s), rd};
  endfunction

  assign rdData = modelRd(regPage, regAddr);

  paged_i2c_target dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaBus),
    .strapSel(strapSel), .shutdownActive(shutdownActive), .rdData(rdData),
    .sdaDriveLow(sdaDriveLow), .wrEn(wrEn), .regAddr(regAddr),
    .regPage(regPage), .wrData(wrData)
  );

  always @(posedge clk) begin
    if (wrEn && evN < 64) begin
      evA[evN] <= regAddr;
      evP[evN] <= regPage;
      evD[evN] <= wrData;
      evN <= evN + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hostBit(input logic b, output logic r);
    repeat (2) @(negedge clk);
    sdaHost = b;
    repeat (6) @(negedge clk);
    sclLine = 1'b1;
    repeat (8) @(negedge clk);
    r = sdaBus;
    sclLine = 1'b0;
  endtask

  task automatic startC();
    sdaHost = 1'b0;
    repeat (8) @(negedge clk);
    sclLine = 1'b0;
  endtask

  task automatic repStart();
    repeat (2) @(negedge clk);
    sdaHost = 1'b1;
    repeat (6) @(negedge clk);
    sclLine = 1'b1;
    repeat (8) @(negedge clk);
    sdaHost = 1'b0;
    repeat (8) @(negedge clk);
    sclLine = 1'b0;
  endtask

  task automatic stopC();
    repeat (2) @(negedge clk);
    sdaHost = 1'b0;
    repeat (6) @(negedge clk);
    sclLine = 1'b1;
    repeat (8) @(negedge clk);
    sdaHost = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic nack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      hostBit(b[i], r);
      if (r !== b[i]) collide++;
    end
    hostBit(1'b1, r);
    nack = r;
  endtask

  task automatic readByte(input bit ackIt, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      hostBit(1'b1, r);
      b[i] = r;
    end
    hostBit(!ackIt, r);
  endtask

  task automatic setPage(input logic [7:0] p);
    logic n;
    startC();
    writeByte(addrByte(strapSel, 1'b0), n);
    writeByte(8'hFD, n);
    writeByte(p, n);
    stopC();
  endtask

  task automatic writeBurst(input logic [7:0] reg0, input int len, input logic [7:0] seed);
    logic n;
    int base;
    int nacks;
    base = evN;
    nacks = 0;
    collide = 0;
    startC();
    writeByte(addrByte(strapSel, 1'b0), n);
    nacks += n;
    writeByte(reg0, n);
    nacks += n;
    for (int i = 0; i < len; i++) begin
      writeByte(seed + 8'(i * 29), n);
      nacks += n;
    end
    stopC();
    check(nacks == 0, "R3", "write nacks", nacks, 0);
    check(collide == 0, "R3", "drive during data bits", collide, 0);
    check(evN == base + len, "R4", "strobe count", evN - base, len);
    for (int i = 0; i < len; i++) begin
      if (base + i < 64) begin
        check(evA[base+i] == reg0 + 8'(i), "R4", "strobe address", evA[base+i], reg0 + 8'(i));
        check(evP[base+i] == regPage, "R4", "strobe page", evP[base+i], regPage);
        check(evD[base+i] == seed + 8'(i * 29), "R4", "strobe data", evD[base+i], seed + 8'(i * 29));
      end
    end
  endtask

  task automatic readBurst(input logic [7:0] p, input logic [7:0] reg0, input int len,
                           input string req);
    logic n;
    logic [7:0] b;
    logic [7:0] expv;
    startC();
    writeByte(addrByte(strapSel, 1'b0), n);
    writeByte(8'hFD, n);
    writeByte(p, n);
    repStart();
    writeByte(addrByte(strapSel, 1'b0), n);
    writeByte(reg0, n);
    repStart();
    writeByte(addrByte(strapSel, 1'b1), n);
    check(n == 1'b0, "R9", "read address ack after repeated start", n, 0);
    for (int i = 0; i < len; i++) begin
      readByte(i != len - 1, b);
      expv = (p != 8'h0B && !shutdownActive) ? 8'h00 : modelRd(p, reg0 + 8'(i));
      check(b == expv, req, "read byte", b, expv);
    end
    stopC();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    logic n;
    logic [7:0] b;
    int base;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    check(sdaDriveLow == 1'b0, "R10", "reset sda drive", sdaDriveLow, 0);
    check(wrEn == 1'b0, "R10", "reset wrEn", wrEn, 0);
    check(regPage == 8'h00, "R10", "reset page", regPage, 0);
    check(regAddr == 8'h00, "R10", "reset pointer", regAddr, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R1: each strap, matching and foreign address
    for (int s = 0; s < 4; s++) begin
      strapSel = 2'(s);
      startC();
      writeByte(addrByte(2'(s), 1'b0), n);
      check(n == 1'b0, "R1", "matching address ack", n, 0);
      stopC();
      startC();
      writeByte(addrByte(2'(s + 1), 1'b0), n);
      check(n == 1'b1, "R1", "foreign strap address nack", n, 1);
      stopC();
    end
    strapSel = 2'd2;

    // R5: command register sets page, no strobe
    base = evN;
    setPage(8'h03);
    check(regPage == 8'h03, "R5", "page after command write", regPage, 3);
    check(evN == base, "R5", "no strobe for command write", evN - base, 0);

    // R4: burst writes
    writeBurst(8'h10, 4, 8'hFF);

    // R2: mismatch ignores bus
    base = evN;
    startC();
    writeByte(8'h55, n);
    check(n == 1'b1, "R2", "wrong address nack", n, 1);
    writeByte(8'h20, n);
    check(n == 1'b1, "R2", "pointer byte ignored", n, 1);
    writeByte(8'h99, n);
    check(n == 1'b1, "R2", "data byte ignored", n, 1);
    stopC();
    check(evN == base, "R2", "no strobe after mismatch", evN - base, 0);

    // R6 / R9: function page read, any shutdown
    shutdownActive = 1'b0;
    readBurst(8'h0B, 8'h05, 3, "R6");

    // R7: after nack the target stays released
    startC();
    writeByte(addrByte(strapSel, 1'b1), n);
    readByte(1'b0, b);
    readByte(1'b0, b);
    check(b == 8'hFF, "R7", "bus released after host nack", b, 8'hFF);
    stopC();

    // R8: frame page gating
    shutdownActive = 1'b0;
    readBurst(8'h02, 8'h40, 2, "R8");
    shutdownActive = 1'b1;
    readBurst(8'h02, 8'h40, 2, "R8");

    // R9: repeated start mid byte
    base = evN;
    startC();
    writeByte(addrByte(strapSel, 1'b0), n);
    hostBit(1'b1, n);
    hostBit(1'b0, n);
    hostBit(1'b1, n);
    repStart();
    writeByte(addrByte(strapSel, 1'b0), n);
    check(n == 1'b0, "R9", "address ack after mid-byte restart", n, 0);
    writeByte(8'h30, n);
    writeByte(8'hAB, n);
    stopC();
    check(evN == base + 1 && evA[base] == 8'h30 && evD[base] == 8'hAB, "R9",
          "write after mid-byte restart", evA[base], 8'h30);
    check(regPage == 8'h02, "R9", "page kept across restart", regPage, 2);

    // random mix
    for (int it = 0; it < 12; it++) begin
      logic [7:0] pg;
      logic [7:0] r0;
      int len;
      pg = ($urandom % 3 == 0) ? 8'h0B : 8'($urandom % 8);
      r0 = 8'($urandom % 224);
      len = 1 + int'($urandom % 4);
      setPage(pg);
      writeBurst(r0, len, 8'($urandom));
      shutdownActive = 1'($urandom % 2);
      readBurst(pg, 8'($urandom % 224), 1 + int'($urandom % 3), pg == 8'h0B ? "R6" : "R8");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule